// File: doc/BRIEF.md
# Toggle-Acknowledged Global Error Register

This block records fatal queue and message-signalled-interrupt abort conditions in a status word whose bits flip, rather than set, when a fault is reported. Each fault source delivers a single-cycle pulse. Software owns a companion acknowledge word; an error bit counts as outstanding while the two words disagree in that bit. To retire every outstanding fault at once, software reads the status word and writes the same value into the acknowledge word.

The outstanding set is the bitwise XOR of status and acknowledge, restricted to a fixed mask of implemented fault positions. A registered interrupt line is driven whenever the outstanding set is non-empty and the global error interrupt enable (bit 0 of the control word) is set. A small two-state machine owns that line: state `IRQ_QUIET` (line low) and state `IRQ_RAISED` (line high). Transition `RAISE` moves from `IRQ_QUIET` to `IRQ_RAISED` when the enable is set and a fault is outstanding; transition `CLEAR` moves back when either condition is gone. All access is through a simple single-cycle register port with word addresses: 0 = status (read-only), 1 = acknowledge (read/write), 2 = control (read/write), 3 = reserved.

Top module: `gerr_toggle_unit`

## Requirements
- R1: After reset the status word, acknowledge word and control word all read as zero and the interrupt output is low.
- R2: A pulse on a fault input whose bit is implemented and not outstanding flips that status bit at the next clock edge; a pulse on a bit that is already outstanding leaves the status bit unchanged.
- R3: The acknowledge word at address 1 stores the low 8 bits of a write and reads them back; writing the current status value retires every outstanding fault.
- R4: The status word at address 0 is read-only: a bus write to it leaves its contents unchanged.
- R5: Bit 1 lies outside the implemented mask 0xFD: a pulse on fault input 1 never changes status, and a difference in bit 1 between status and acknowledge never counts as outstanding.
- R6: The control word at address 2 holds only the interrupt enable in bit 0; other written bits read as zero, and with the enable clear the interrupt stays low.
- R7: The interrupt output is registered: it rises in the cycle after the enable is set with a fault outstanding (or a fault becomes outstanding with the enable set), and drops in the cycle after an acknowledge write retires the last outstanding fault or the enable is cleared.
- R8: Fault positions: command error at bit 0, event-queue abort at 2, page-request-queue abort at 3, command-queue MSI abort at 4, event-queue MSI abort at 5, page-request-queue MSI abort at 6, generic MSI abort at 7.
- R9: A fault reported again after acknowledgement flips the status bit back, and the bit is outstanding again even though its status value returned to zero.
- R10: Address 3 reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 8 | Single-cycle fault pulses, one per bit position |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Registered global error interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit data word, 2-bit address, 8 fault positions and the mask 0xFD. The unimplemented bit 1 inside that mask brings the ignored-position behaviour within reach, and the 32-bit write width lets all-ones writes show that bits above the stored field are discarded. Every implemented position is walked through raise, acknowledge and re-raise, with the interrupt sampled both in the cycle just after each change and the one after that to expose its one-cycle register delay.

// File: rtl/gerr_pkg.sv
package gerr_pkg;

    // Word addresses on the register port
    localparam logic [1:0] ADR_STATUS = 2'd0;
    localparam logic [1:0] ADR_ACK    = 2'd1;
    localparam logic [1:0] ADR_CTRL   = 2'd2;

    // Fault bit positions
    localparam int unsigned POS_CMD_ERR     = 0;
    localparam int unsigned POS_EVT_ABORT   = 2;
    localparam int unsigned POS_PRQ_ABORT   = 3;
    localparam int unsigned POS_MSI_CMD     = 4;
    localparam int unsigned POS_MSI_EVT     = 5;
    localparam int unsigned POS_MSI_PRQ     = 6;
    localparam int unsigned POS_MSI_GENERIC = 7;

    // Position of the enable inside the control word
    localparam int unsigned POS_IRQ_EN = 0;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/gerr_status_bank.sv
module gerr_status_bank #(
    parameter int unsigned      SRC_W    = 8,
    parameter logic [SRC_W-1:0] ERR_MASK = 8'hFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] err_pulse,
    input  logic             ack_we,
    input  logic [SRC_W-1:0] ack_wdata,
    output logic [SRC_W-1:0] status_q,
    output logic [SRC_W-1:0] ack_q,
    output logic [SRC_W-1:0] active
);

    logic pulse_unused;
    assign pulse_unused = ^(err_pulse & ~ERR_MASK);

    // Outstanding faults: disagreement inside the implemented mask
    assign active = (status_q ^ ack_q) & ERR_MASK;

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (ERR_MASK[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status_q[i] <= 1'b0;
                end else if (err_pulse[i] && !active[i]) begin
                    status_q[i] <= ~status_q[i];
                end
            end
        end else begin : g_none
            assign status_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else if (ack_we) begin
            ack_q <= ack_wdata;
        end
    end

endmodule

// File: rtl/gerr_reg_port.sv
module gerr_reg_port
    import gerr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned SRC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [SRC_W-1:0]  status_q,
    input  logic [SRC_W-1:0]  ack_q,
    output logic              ack_we,
    output logic [SRC_W-1:0]  ack_wdata,
    output logic              irq_en,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int unsigned WORDS = 1 << ADDR_W;

    logic wr_ack;
    logic wr_ctrl;
    logic rd_strobe;
    logic wdata_unused;
    logic [WORDS-1:0][DATA_W-1:0] word_view;

    assign wdata_unused = ^reg_wdata[DATA_W-1:SRC_W];

    assign wr_ack    = reg_sel && reg_wr && (reg_addr == ADDR_W'(ADR_ACK));
    assign wr_ctrl   = reg_sel && reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
    assign rd_strobe = reg_sel && !reg_wr;

    assign ack_we    = wr_ack;
    assign ack_wdata = reg_wdata[SRC_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            irq_en <= reg_wdata[POS_IRQ_EN];
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_comb begin
            word_view[w] = '0;
            if (w == int'(ADR_STATUS)) begin
                word_view[w][SRC_W-1:0] = status_q;
            end else if (w == int'(ADR_ACK)) begin
                word_view[w][SRC_W-1:0] = ack_q;
            end else if (w == int'(ADR_CTRL)) begin
                word_view[w][POS_IRQ_EN] = irq_en;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_strobe) begin
            reg_rdata = word_view[reg_addr];
        end
    end

endmodule

// File: rtl/gerr_irq_fsm.sv
module gerr_irq_fsm
    import gerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic any_active,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (irq_en && any_active) begin
                    state_d = IRQ_RAISED;
                end
            end
            IRQ_RAISED: begin
                if (!irq_en || !any_active) begin
                    state_d = IRQ_QUIET;
                end
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/gerr_toggle_unit.sv
module gerr_toggle_unit #(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      ADDR_W   = 2,
    parameter int unsigned      SRC_W    = 8,
    parameter logic [SRC_W-1:0] ERR_MASK = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  err_pulse,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [SRC_W-1:0] status_q;
    logic [SRC_W-1:0] ack_q;
    logic [SRC_W-1:0] active;
    logic [SRC_W-1:0] ack_wdata;
    logic             ack_we;
    logic             irq_en;
    logic             any_active;

    assign any_active = |active;

    gerr_status_bank #(
        .SRC_W    (SRC_W),
        .ERR_MASK (ERR_MASK)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (err_pulse),
        .ack_we    (ack_we),
        .ack_wdata (ack_wdata),
        .status_q  (status_q),
        .ack_q     (ack_q),
        .active    (active)
    );

    gerr_reg_port #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SRC_W  (SRC_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_q  (status_q),
        .ack_q     (ack_q),
        .ack_we    (ack_we),
        .ack_wdata (ack_wdata),
        .irq_en    (irq_en),
        .reg_rdata (reg_rdata)
    );

    gerr_irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_en     (irq_en),
        .any_active (any_active),
        .irq        (irq)
    );

endmodule

// File: rtl/gerr_toggle_checker.sv
module gerr_toggle_checker #(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      ADDR_W   = 2,
    parameter int unsigned      SRC_W    = 8,
    parameter logic [SRC_W-1:0] ERR_MASK = 8'hFD
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  err_pulse,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic [SRC_W-1:0]  status_q,
    input logic [SRC_W-1:0]  active,
    input logic [SRC_W-1:0]  ack_q,
    input logic              irq_en
);

    // R2: status bits change only where a pulse hit a quiet implemented bit
    p_toggle_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_q ^ $past(status_q)) &
                   ~($past(err_pulse) & ERR_MASK & ~$past(active))) == '0));

    // R2: every pulse on a quiet implemented bit flips it
    p_toggle_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_pulse & ERR_MASK & ~active)) |=>
        (((status_q ^ $past(status_q)) & $past(err_pulse & ERR_MASK & ~active))
          == $past(err_pulse & ERR_MASK & ~active)));

    // R4: bus writes to the status word leave it untouched
    p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == '0 && err_pulse == '0) |=> $stable(status_q));

    // R3: acknowledge word takes the written low bits
    p_ack_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == ADDR_W'(1)) |=> (ack_q == $past(reg_wdata[SRC_W-1:0])));

    // R7: interrupt high only if enable and an outstanding fault held one cycle earlier
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(irq_en) && $past(|active)));

    // R7: interrupt drops one cycle after its cause is gone
    p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || active == '0) |=> !irq);

endmodule

bind gerr_toggle_unit gerr_toggle_checker #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SRC_W    (SRC_W),
    .ERR_MASK (ERR_MASK)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_pulse (err_pulse),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .status_q  (status_q),
    .active    (active),
    .ack_q     (ack_q),
    .irq_en    (irq_en)
);

// File: tb/tb_gerr_toggle_unit.sv
module tb_gerr_toggle_unit;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned SRC_W  = 8;
    localparam logic [7:0]  MASK   = 8'hFD;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SRC_W-1:0]  err_pulse = '0;
    logic              reg_sel = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    always #4 clk = ~clk;   // 125 MHz

    gerr_toggle_unit #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .SRC_W (SRC_W), .ERR_MASK (MASK)
    ) dut (
        .clk (clk), .rst_n (rst_n), .err_pulse (err_pulse),
        .reg_sel (reg_sel), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic  mon_read = 1'b0;
    logic  mon_irq  = 1'b0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    // Bench-side model of the programmer-visible state
    logic [7:0] m_status = '0;
    logic [7:0] m_ack    = '0;
    logic       m_en     = 1'b0;

    function automatic logic [31:0] m_read(input logic [1:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            2'd0: v[7:0] = m_status;
            2'd1: v[7:0] = m_ack;
            2'd2: v[0]   = m_en;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (mon_read || mon_irq) begin
            item_t       it;
            logic [31:0] act;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL bench queue empty: actual=0 expected=1");
            end else begin
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic drive_idle();
        @(posedge clk);
        #1;
        reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        err_pulse = '0; mon_read = 1'b0; mon_irq = 1'b0;
    endtask

    task automatic do_pulse(input logic [7:0] p);
        drive_idle();
        err_pulse = p;
        m_status = m_status ^ (p & MASK & ~((m_status ^ m_ack) & MASK));
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        drive_idle();
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 2'd1) m_ack = d[7:0];
        if (a == 2'd2) m_en  = d[0];
    endtask

    task automatic expect_read(input logic [1:0] a, input string tag);
        drive_idle();
        reg_sel = 1'b1; reg_addr = a; mon_read = 1'b1;
        sb_q.push_back('{1'b0, m_read(a), tag});
    endtask

    task automatic expect_irq(input bit e, input string tag);
        drive_idle();
        mon_irq = 1'b1;
        sb_q.push_back('{1'b1, {31'b0, e}, tag});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_read(2'd0, "R1 status after reset");
        expect_read(2'd1, "R1 ack after reset");
        expect_read(2'd2, "R1 ctrl after reset");
        expect_irq(1'b0, "R1 irq after reset");

        // R2 / R8 command error at bit 0, enable still off (R6)
        do_pulse(8'h01);
        expect_read(2'd0, "R2 R8 bit0 toggles");
        expect_irq(1'b0, "R6 irq held low while disabled");

        // R6 / R7 enable with fault outstanding
        do_write(2'd2, 32'hFFFF_FFFF);
        expect_irq(1'b0, "R7 rise waits one cycle");
        expect_irq(1'b1, "R7 irq raised");
        expect_read(2'd2, "R6 ctrl keeps only bit0");

        // R2 repeated fault while outstanding
        do_pulse(8'h01);
        expect_read(2'd0, "R2 no self-cancel");

        // R4 status is read-only
        do_write(2'd0, 32'h0000_00FF);
        expect_read(2'd0, "R4 status write ignored");

        // R5 bit 1 input ignored
        do_pulse(8'h02);
        expect_read(2'd0, "R5 bit1 pulse ignored");

        // R3 / R7 acknowledge retires fault
        do_write(2'd1, {24'hFFFFFF, m_status});
        expect_irq(1'b1, "R7 irq holds one cycle after ack");
        expect_irq(1'b0, "R7 irq drops after ack");
        expect_read(2'd1, "R3 ack readback low bits");

        // R8 all positions together
        do_pulse(8'hFC);
        expect_read(2'd0, "R8 all fault positions");
        expect_irq(1'b1, "R8 irq from upper positions");
        do_write(2'd1, {24'h0, m_status});
        drive_idle();
        expect_irq(1'b0, "R3 writing status value clears all");

        // R9 re-raise after acknowledge
        do_pulse(8'h01);
        expect_read(2'd0, "R9 toggles back to zero");
        expect_irq(1'b1, "R9 outstanding again");
        do_write(2'd1, {24'h0, m_status});
        drive_idle();
        expect_irq(1'b0, "R9 retired again");

        // R5 ack bit1 difference does not count
        do_write(2'd1, {24'h0, m_status ^ 8'h02});
        expect_read(2'd1, "R5 ack bit1 stored");
        drive_idle();
        expect_irq(1'b0, "R5 bit1 difference not outstanding");
        do_write(2'd1, {24'h0, m_status});

        // R8 walk each implemented position
        for (int b = 0; b < 8; b++) begin
            if (b != 1) begin
                do_pulse(8'(1 << b));
                expect_read(2'd0, $sformatf("R8 position %0d toggles", b));
                expect_irq(1'b1, $sformatf("R8 position %0d raises irq", b));
                do_write(2'd1, {24'h0, m_status});
                drive_idle();
                expect_irq(1'b0, $sformatf("R3 position %0d retired", b));
            end
        end

        // R7 / R6 disable drops interrupt
        do_pulse(8'h08);
        drive_idle();
        expect_irq(1'b1, "R7 raised before disable");
        do_write(2'd2, 32'h0);
        expect_irq(1'b1, "R7 holds one cycle after disable");
        expect_irq(1'b0, "R6 R7 disable drops irq");
        do_write(2'd1, {24'h0, m_status});

        // R10 reserved address
        do_write(2'd3, 32'hFFFF_FFFF);
        expect_read(2'd3, "R10 reserved reads zero");
        expect_read(2'd1, "R10 write had no effect on ack");
        expect_read(2'd2, "R10 write had no effect on ctrl");

        drive_idle();
        drive_idle();
        done = 1'b1;
        finish_run();
    end

endmodule